// File: doc/BRIEF.md
# Slot Access Timeout Guard

This block watches every bus cycle that a cycle engine runs toward a peripheral slot. When the engine starts an access on a slot, a private counter for that slot begins to run. The counter stops if the slot acknowledges. If the slot stays silent for the whole timeout window, the guard completes the access itself. It pulses a forced-completion strobe back to the cycle engine and offers a fixed fill word as read data, so the host transaction finishes normally and the host bus is not held.

A timeout also records a bus fault in a status bit that belongs to that slot alone. The bit stays set until software writes a one to clear it. Separate bits per slot let independent software threads handle their own slot's faults without interfering with each other. Each status bit can be routed to a shared interrupt line through a per-slot enable.

Top module: `slot_access_watchdog`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `force_done`, `bus_err`, `irq` and `fill_rdata` are all zero.
- R2: Suppose `acc_start[i]` is sampled high at clock edge E and `slot_ack[i]` is not sampled high at edges E+1 through E+TIMEOUT. Then `force_done[i]` is high for exactly one cycle, the cycle that follows edge E+TIMEOUT.
- R3: A `slot_ack[i]` sampled at any edge from E+1 to E+TIMEOUT ends the access with no forced completion and no error. This includes an acknowledge on the same edge at which the count would expire.
- R4: `acc_start[i]` restarts the slot's full timeout window even while an access on that slot is already being timed.
- R5: A forced completion on slot i sets `bus_err[i]` in the same cycle that `force_done[i]` is high. Bits of other slots are unaffected.
- R6: `bus_err[i]` holds its value until `err_clr[i]` is sampled high, which clears it. If a timeout and a clear meet on the same edge, the bit stays set.
- R7: `irq` is high exactly when some slot i has both `bus_err[i]` and `irq_en[i]` high.
- R8: `fill_rdata` equals FILL_WORD (all ones by default) in any cycle where some `force_done` bit is high, and is zero otherwise.
- R9: `slot_ack[i]` on an idle slot has no effect. When `acc_start[i]` and `slot_ack[i]` are sampled together, the start wins and the acknowledge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_start | input | NUM_SLOTS | One-cycle pulse per slot: an access begins |
| slot_ack | input | NUM_SLOTS | Per-slot acknowledge from the slot |
| err_clr | input | NUM_SLOTS | Write-one-to-clear strobes for the fault bits |
| irq_en | input | NUM_SLOTS | Per-slot interrupt enable |
| force_done | output | NUM_SLOTS | One-cycle forced-completion strobe to the cycle engine |
| fill_rdata | output | DATA_W | Read data to return on a forced completion |
| bus_err | output | NUM_SLOTS | Sticky per-slot bus fault status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `acc_start` is a single-cycle pulse from the cycle engine and that acknowledges are meaningful only inside an access. They also assume that `err_clr` and `irq_en` may change on any cycle. The stimulus drives all inputs one time unit after the rising edge. Starts are drawn sparsely, so most accesses run to an acknowledge or to expiry. Acknowledges and clears are drawn freely, including on idle slots and on expiry edges. The directed part places acknowledges, restarts and clears on the exact edges named in R3, R4, R6 and R9.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_WAIT = 1'b1
  } slot_state_e;

  // Width of a counter that must hold 0 .. limit-1, never below one bit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    int unsigned w;
    w = $clog2(limit);
    return (w < 1) ? 1 : w;
  endfunction

  // True on the last counted cycle of a window of length limit.
  function automatic logic window_last(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

  // Next sticky value: a new fault dominates a clear request.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/wdt_slot_timer.sv
module wdt_slot_timer
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic busy,
  output logic expire,
  output logic ack_hit,
  output logic force_done
);

  localparam int unsigned CW = cnt_width(TIMEOUT);

  slot_state_e     state_q;
  logic [CW-1:0]   count_q;

  // Internal events, named so the checks below can see them.
  always_comb begin
    ack_hit = (state_q == SLOT_WAIT) && !start && ack;
    expire  = (state_q == SLOT_WAIT) && !start && !ack &&
              window_last(int'(count_q), TIMEOUT);
  end

  assign busy = (state_q == SLOT_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SLOT_IDLE;
      count_q    <= '0;
      force_done <= 1'b0;
    end else begin
      force_done <= expire;
      if (start) begin
        state_q <= SLOT_WAIT;
        count_q <= '0;
      end else if (ack_hit || expire) begin
        state_q <= SLOT_IDLE;
        count_q <= '0;
      end else if (state_q == SLOT_WAIT) begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  AST_COUNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(count_q) < TIMEOUT)); // R2

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    force_done |=> !force_done); // R2

  AST_ACK_NO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> !force_done); // R3

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !force_done)); // R4

  AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && !force_done)); // R9

endmodule

// File: rtl/wdt_err_status.sv
module wdt_err_status
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] set,
  input  logic [NUM_SLOTS-1:0] clr,
  output logic [NUM_SLOTS-1:0] err
);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err[i] <= 1'b0;
      else        err[i] <= sticky_next(err[i], set[i], clr[i]);
    end

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (err[i] && !clr[i]) |=> err[i]); // R6

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !err[i]); // R6

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> err[i]); // R5

    AST_ERR_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!err[i] && !set[i]) |=> !err[i]); // R5
  end

endmodule

// File: rtl/slot_access_watchdog.sv
module slot_access_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned TIMEOUT   = 1024,
  parameter int unsigned DATA_W    = 32,
  parameter logic [DATA_W-1:0] FILL_WORD = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] acc_start,
  input  logic [NUM_SLOTS-1:0] slot_ack,
  input  logic [NUM_SLOTS-1:0] err_clr,
  input  logic [NUM_SLOTS-1:0] irq_en,
  output logic [NUM_SLOTS-1:0] force_done,
  output logic [DATA_W-1:0]    fill_rdata,
  output logic [NUM_SLOTS-1:0] bus_err,
  output logic                 irq
);

  logic [NUM_SLOTS-1:0] slot_busy;
  logic [NUM_SLOTS-1:0] slot_expire;
  logic [NUM_SLOTS-1:0] slot_ack_hit;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    wdt_slot_timer #(
      .TIMEOUT (TIMEOUT)
    ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (acc_start[i]),
      .ack        (slot_ack[i]),
      .busy       (slot_busy[i]),
      .expire     (slot_expire[i]),
      .ack_hit    (slot_ack_hit[i]),
      .force_done (force_done[i])
    );

    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      force_done[i] |-> bus_err[i]); // R5

    AST_NO_DOUBLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(slot_expire[i] && slot_ack_hit[i])); // R3
  end

  wdt_err_status #(
    .NUM_SLOTS (NUM_SLOTS)
  ) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (slot_expire),
    .clr   (err_clr),
    .err   (bus_err)
  );

  assign irq        = |(bus_err & irq_en);
  assign fill_rdata = (|force_done) ? FILL_WORD : '0;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq); // R7

  AST_IRQ_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err == '0) |-> !irq); // R7

  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (force_done == '0) |-> (fill_rdata == '0)); // R8

  AST_DONE_ONEHOT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (|force_done) |-> $past(|slot_busy)); // R2

endmodule

// File: tb/slot_access_watchdog_test.sv
`timescale 1ns/1ps
module slot_access_watchdog_test;

  localparam int N  = 2;
  localparam int T  = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  acc_start = '0, slot_ack = '0, err_clr = '0, irq_en = '0;
  logic [N-1:0]  force_done, bus_err;
  logic [DW-1:0] fill_rdata;
  logic          irq;

  int total = 0;
  int bad   = 0;
  bit armed = 1'b0;

  // Reference model state
  bit m_busy[N];
  int m_elapsed[N];
  bit m_fd[N];
  bit m_err[N];

  always #4 clk = ~clk;

  slot_access_watchdog #(
    .NUM_SLOTS (N), .TIMEOUT (T), .DATA_W (DW)
  ) uut (
    .clk (clk), .rst_n (rst_n), .acc_start (acc_start), .slot_ack (slot_ack),
    .err_clr (err_clr), .irq_en (irq_en), .force_done (force_done),
    .fill_rdata (fill_rdata), .bus_err (bus_err), .irq (irq)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model: elapsed counts edges since the start; expiry at the T-th quiet edge.
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      bit fault;
      fault = 1'b0;
      if (!rst_n) begin
        m_busy[i] = 0; m_elapsed[i] = 0; m_fd[i] = 0; m_err[i] = 0;
      end else begin
        if (acc_start[i]) begin
          m_busy[i] = 1; m_elapsed[i] = 0;
        end else if (m_busy[i] && slot_ack[i]) begin
          m_busy[i] = 0;
        end else if (m_busy[i]) begin
          m_elapsed[i]++;
          if (m_elapsed[i] == T) begin
            m_busy[i] = 0; fault = 1;
          end
        end
        m_fd[i] = fault;
        if (fault) m_err[i] = 1;
        else if (err_clr[i]) m_err[i] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      bit any_fd, any_irq;
      any_fd = 0; any_irq = 0;
      for (int i = 0; i < N; i++) begin
        check("R2/R3 force_done", force_done[i], m_fd[i]);
        check("R5/R6 bus_err", bus_err[i], m_err[i]);
        any_fd  |= m_fd[i];
        any_irq |= m_err[i] & irq_en[i];
      end
      check("R7 irq", irq, any_irq);
      check("R8 fill_rdata", fill_rdata, any_fd ? {DW{1'b1}} : 0);
    end
  end

  task automatic cyc(input logic [N-1:0] s, input logic [N-1:0] a,
                     input logic [N-1:0] c, input logic [N-1:0] e);
    @(posedge clk); #1;
    acc_start = s; slot_ack = a; err_clr = c; irq_en = e;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc('0, '0, '0, irq_en);
  endtask

  initial begin
    #(8 * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset force_done", force_done, 0);
    check("R1 reset bus_err", bus_err, 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset fill", fill_rdata, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    armed = 1'b1;
    @(negedge clk);
    check("R1 first cycle bus_err", bus_err, 0);

    // R3: acknowledge lands on the expiry edge
    cyc(2'b01, 0, 0, 0); idle(T - 1); cyc(0, 2'b01, 0, 0); idle(3);
    @(negedge clk); check("R3 ack at expiry edge", bus_err, 0);

    // R2/R5: slot 1 times out, slot 0 untouched
    cyc(2'b10, 0, 0, 0); idle(T + 2);
    @(negedge clk); check("R5 only slot1 faulted", bus_err, 2'b10);

    // R7: enable interrupt for slot 1
    cyc(0, 0, 0, 2'b10); idle(1);
    @(negedge clk); check("R7 irq enabled", irq, 1);
    cyc(0, 0, 0, 2'b01); idle(1);
    @(negedge clk); check("R7 irq masked", irq, 0);

    // R6: clear slot 1
    cyc(0, 0, 2'b10, 0); idle(2);
    @(negedge clk); check("R6 clear", bus_err, 0);

    // R4: restart before expiry, then ack inside the second window
    cyc(2'b01, 0, 0, 0); idle(T - 1); cyc(2'b01, 0, 0, 0); idle(T - 1);
    cyc(0, 2'b01, 0, 0); idle(3);
    @(negedge clk); check("R4 restart extends window", bus_err, 0);

    // R9: idle ack ignored; start+ack together keeps timing
    cyc(0, 2'b11, 0, 0); idle(2);
    @(negedge clk); check("R9 idle ack", force_done, 0);
    cyc(2'b01, 2'b01, 0, 0); idle(T + 2);
    @(negedge clk); check("R9 start beats ack", bus_err, 2'b01);

    // R6: clear meets a new fault on the same edge
    cyc(0, 0, 2'b01, 0); idle(1);
    cyc(2'b01, 0, 0, 0); idle(T - 1); cyc(0, 0, 2'b01, 0); idle(2);
    @(negedge clk); check("R6 set beats clear", bus_err, 2'b01);
    cyc(0, 0, 2'b11, 0); idle(2);

    // Random traffic, compared every cycle against the model
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] s, a, c;
      logic [N-1:0] e;
      for (int i = 0; i < N; i++) begin
        s[i] = ($urandom % 12) == 0;
        a[i] = ($urandom % 6) == 0;
        c[i] = ($urandom % 10) == 0;
      end
      e = ((k % 30) == 0) ? N'($urandom) : irq_en;
      cyc(s, a, c, e);
    end
    idle(T + 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule